// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the command side of an SDRAM controller or memory model. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable. It turns them into a single decoded command and applies that command to one of four banks, chosen by a two-bit bank address. It keeps an open/idle flag for each bank. It also keeps the row address of the last activate, the column address of the last legal access, and the op-code of the last mode-register load.

Address bit 10 plays two parts. On a read or write it asks for an automatic close of the bank. On a precharge it widens the precharge from the one selected bank to every bank. A read or write to a bank that is not open is reported as illegal and leaves all state as it was. The block is pure bookkeeping: it checks no timing parameter and moves no data.

All outputs are registered. Results for a command sampled on edge N appear just after edge N. Strobes last one cycle.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While chip select is high at a sampling edge, no strobe fires and no bank state or captured register changes, whatever the other three pins are.
- R2: Chip select low, row strobe low, column strobe high and write enable high (activate) pulses `act_o`, opens the bank on `ba_i`, loads all 13 address bits into `row_o` and the bank into `bank_o`.
- R3: Chip select low, row strobe low, column strobe high and write enable low (precharge) with address bit 10 low pulses `pre_o` and closes only the selected bank.
- R4: Precharge with address bit 10 high pulses `pre_o` and `pre_all_o` and closes all four banks.
- R5: Chip select low, row strobe high and column strobe low to an open bank pulses `rd_o` (write enable high) or `wr_o` (write enable low), and loads address bits 8..0 into `col_o` and the bank into `bank_o`.
- R6: A legal read or write with address bit 10 high also pulses `auto_pre_o`. Its bank stays open on the edge of the command and is closed on the next edge. If that next edge carries an activate to the same bank, the bank stays open.
- R7: A read or write to a bank that is idle, or that is closing on that edge, pulses `illegal_o` and loads `bank_o`. It pulses neither `rd_o` nor `wr_o`, and changes neither `col_o` nor any bank state.
- R8: All four command pins low (mode register set) pulses `mrs_o` and loads the 13 address bits into `mode_o`.
- R9: Chip select, row strobe and column strobe low with write enable high (auto-refresh) pulses `ref_o` only. The pattern row strobe high, column strobe high, write enable low acts as no operation.
- R10: After reset all banks are idle, every strobe is low, and all captured registers are zero.
- R11: At most one of `act_o`, `rd_o`, `wr_o`, `pre_o`, `ref_o`, `mrs_o` and `illegal_o` is high in any cycle.
- R12: `all_idle_o` is high exactly when no bit of `bank_active_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; command pins sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address / op-code bus; bit 10 is the precharge qualifier |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Legal read strobe |
| wr_o | output | 1 | Legal write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Auto-refresh strobe |
| mrs_o | output | 1 | Mode register set strobe |
| illegal_o | output | 1 | Access to a non-open bank |
| auto_pre_o | output | 1 | Access carries automatic close |
| pre_all_o | output | 1 | Precharge applies to all banks |
| bank_o | output | 2 | Bank of the last activate, precharge, read, write or illegal access |
| row_o | output | 13 | Row of the last activate |
| col_o | output | 9 | Column of the last legal read or write |
| mode_o | output | 13 | Last mode-register op-code |
| bank_active_o | output | 4 | Open flag per bank |
| all_idle_o | output | 1 | No bank open |

## Verification
The assertions check several rules on every cycle. At most one strobe fires at a time, and the idle flag matches the bank vector. A bank is open whenever an activate or a legal access names it, and it is idle whenever an illegal access names it. A precharge-all leaves every bank closed, and an auto-precharge closes its bank on the following edge. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers chip select masking commands, the exact row, column and op-code bits captured, the no-operation handling of burst-stop, and the case where an activate lands on the same edge as a pending auto-close.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } sdram_cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dec_pkg::*;
(
  input  logic       cs_n_i,
  input  logic       ras_n_i,
  input  logic       cas_n_i,
  input  logic       we_n_i,
  output sdram_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_n_i) begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        default: cmd_o = CMD_NOP; // burst stop and nop
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_dec_pkg::*;
#(
  parameter  int BANK_W = 2,
  localparam int NB     = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdram_cmd_e        cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              ap_i,
  output logic [NB-1:0]     bank_active_o,
  output logic              access_ok_o,
  output logic              illegal_o
);
  logic [NB-1:0] open_q, close_q, open_d, close_d, eff;
  logic          is_access;

  // banks with a pending auto-close count as idle this edge
  assign eff       = open_q & ~close_q;
  assign is_access = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign access_ok_o = is_access && eff[ba_i];
  assign illegal_o   = is_access && !eff[ba_i];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel, od, cd;
    assign sel = (ba_i == BANK_W'(b));
    always_comb begin
      od = eff[b];
      cd = 1'b0;
      unique case (cmd_i)
        CMD_ACT: if (sel) od = 1'b1;
        CMD_PRE: if (sel || ap_i) od = 1'b0;
        CMD_RD, CMD_WR: if (sel && eff[b] && ap_i) cd = 1'b1;
        default: ;
      endcase
    end
    assign open_d[b]  = od;
    assign close_d[b] = cd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= '0;
      close_q <= '0;
    end else begin
      open_q  <= open_d;
      close_q <= close_d;
    end
  end

  assign bank_active_o = open_q;

  // R4
  pre_all_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && ap_i) |=> (open_q == '0));

  // R6
  ap_pending_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_q != '0) |-> ((open_q & close_q) == close_q));
endmodule

// File: rtl/sdram_addr_capture.sv
module sdram_addr_capture
  import sdram_dec_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdram_cmd_e        cmd_i,
  input  logic              access_ok_i,
  input  logic              illegal_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] mode_o
);
  logic bank_en;
  assign bank_en = (cmd_i == CMD_ACT) || (cmd_i == CMD_PRE) || access_ok_i || illegal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      row_o  <= '0;
      col_o  <= '0;
      mode_o <= '0;
    end else begin
      if (bank_en)            bank_o <= ba_i;
      if (cmd_i == CMD_ACT)   row_o  <= addr_i;
      if (access_ok_i)        col_o  <= addr_i[COL_W-1:0];
      if (cmd_i == CMD_MRS)   mode_o <= addr_i;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_dec_pkg::*;
#(
  parameter  int ADDR_W = 13,
  parameter  int COL_W  = 9,
  parameter  int BANK_W = 2,
  parameter  int AP_BIT = 10,
  localparam int NB     = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              pre_o,
  output logic              ref_o,
  output logic              mrs_o,
  output logic              illegal_o,
  output logic              auto_pre_o,
  output logic              pre_all_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] mode_o,
  output logic [NB-1:0]     bank_active_o,
  output logic              all_idle_o
);
  sdram_cmd_e cmd;
  logic       access_ok, illegal, ap_bit;

  assign ap_bit = addr_i[AP_BIT];

  sdram_cmd_decode u_decode (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .cmd_o  (cmd)
  );

  sdram_bank_tracker #(.BANK_W(BANK_W)) u_banks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .ba_i         (ba_i),
    .ap_i         (ap_bit),
    .bank_active_o(bank_active_o),
    .access_ok_o  (access_ok),
    .illegal_o    (illegal)
  );

  sdram_addr_capture #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .access_ok_i(access_ok),
    .illegal_i  (illegal),
    .ba_i       (ba_i),
    .addr_i     (addr_i),
    .bank_o     (bank_o),
    .row_o      (row_o),
    .col_o      (col_o),
    .mode_o     (mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o      <= 1'b0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      pre_o      <= 1'b0;
      ref_o      <= 1'b0;
      mrs_o      <= 1'b0;
      illegal_o  <= 1'b0;
      auto_pre_o <= 1'b0;
      pre_all_o  <= 1'b0;
    end else begin
      act_o      <= (cmd == CMD_ACT);
      rd_o       <= (cmd == CMD_RD) && access_ok;
      wr_o       <= (cmd == CMD_WR) && access_ok;
      pre_o      <= (cmd == CMD_PRE);
      ref_o      <= (cmd == CMD_REF);
      mrs_o      <= (cmd == CMD_MRS);
      illegal_o  <= illegal;
      auto_pre_o <= access_ok && ap_bit;
      pre_all_o  <= (cmd == CMD_PRE) && ap_bit;
    end
  end

  assign all_idle_o = (bank_active_o == '0);

  // R11
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o}));

  // R12
  idle_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_o == ($countones(bank_active_o) == 0));

  // R2
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> bank_active_o[bank_o]);

  // R5
  access_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> bank_active_o[bank_o]);

  // R7
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !bank_active_o[bank_o]);

  // R4
  pre_all_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |-> (pre_o && all_idle_o));

  // R6
  auto_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |=> (!bank_active_o[$past(bank_o)] || (act_o && bank_o == $past(bank_o))));

  // R8
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_o |=> $stable(mode_o) || mrs_o);
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
  typedef struct packed {
    logic [6:0]  strb;     // act rd wr pre ref mrs illegal
    logic        ap;
    logic        pall;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [8:0]  col;
    logic [12:0] mode;
    logic [3:0]  active;
    logic        idle;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic act, rd, wr, pre, rf, mrs, ill, ap, pall, idle;
  logic [1:0]  bank;
  logic [12:0] row, mode;
  logic [8:0]  col;
  logic [3:0]  active;

  int n_chk = 0, n_bad = 0;
  exp_t  q[$];
  string tq[$];

  // reference model state
  logic [3:0]  m_open = '0, m_close = '0;
  logic [1:0]  m_bank = '0;
  logic [12:0] m_row = '0, m_mode = '0;
  logic [8:0]  m_col = '0;

  always #2 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .act_o(act), .rd_o(rd), .wr_o(wr),
    .pre_o(pre), .ref_o(rf), .mrs_o(mrs), .illegal_o(ill), .auto_pre_o(ap),
    .pre_all_o(pall), .bank_o(bank), .row_o(row), .col_o(col), .mode_o(mode),
    .bank_active_o(active), .all_idle_o(idle)
  );

  task automatic issue(input string tag, input logic c, input logic r, input logic a,
                       input logic w, input logic [1:0] b, input logic [12:0] ad);
    exp_t e;
    logic [3:0] eff, nclose;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    e = '0;
    eff = m_open & ~m_close;
    nclose = '0;
    m_open = eff;
    if (!c) begin
      case ({r, a, w})
        3'b011: begin e.strb[6] = 1'b1; m_open[b] = 1'b1; m_row = ad; m_bank = b; end
        3'b010: begin
          e.strb[3] = 1'b1; e.pall = ad[10]; m_bank = b;
          if (ad[10]) m_open = '0; else m_open[b] = 1'b0;
        end
        3'b101, 3'b100: begin
          m_bank = b;
          if (eff[b]) begin
            if (w) e.strb[5] = 1'b1; else e.strb[4] = 1'b1;
            m_col = ad[8:0]; e.ap = ad[10]; nclose[b] = ad[10];
          end else e.strb[0] = 1'b1;
        end
        3'b001: e.strb[2] = 1'b1;
        3'b000: begin e.strb[1] = 1'b1; m_mode = ad; end
        default: ;
      endcase
    end
    m_close = nclose;
    e.bank = m_bank; e.row = m_row; e.col = m_col; e.mode = m_mode;
    e.active = m_open; e.idle = (m_open == '0);
    q.push_back(e);
    tq.push_back(tag);
  endtask

  // monitor: one item per sampling edge
  always @(posedge clk) begin
    exp_t e, got;
    string t;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tq.pop_front();
      got = '{strb: {act, rd, wr, pre, rf, mrs, ill}, ap: ap, pall: pall, bank: bank,
              row: row, col: col, mode: mode, active: active, idle: idle};
      n_chk++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, got, e);
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    // R10 reset state
    n_chk++;
    if ({act, rd, wr, pre, rf, mrs, ill, ap, pall} !== '0 || active !== 4'h0 || idle !== 1'b1 ||
        row !== '0 || col !== '0 || mode !== '0 || bank !== '0) begin
      n_bad++;
      $display("FAIL R10: actual act=%b active=%h idle=%b expected 0/0/1", act, active, idle);
    end
    @(negedge clk); rst_n = 1'b1;
    issue("R1 cs high act pattern", 1, 0, 1, 1, 2'd1, 13'h1234);
    issue("R2 activate b0",          0, 0, 1, 1, 2'd0, 13'h1ABC);
    issue("R2 activate b2",          0, 0, 1, 1, 2'd2, 13'h0FFF);
    issue("R12 idle low",            1, 1, 1, 1, 2'd0, 13'h0000);
    issue("R5 read b0",              0, 1, 0, 1, 2'd0, 13'h01A5);
    issue("R6 write b2 autopre",     0, 1, 0, 0, 2'd2, 13'h04FF);
    issue("R6 close next edge",      1, 1, 1, 1, 2'd0, 13'h0000);
    issue("R7 read idle b3",         0, 1, 0, 1, 2'd3, 13'h0033);
    issue("R7 write idle b2",        0, 1, 0, 0, 2'd2, 13'h0044);
    issue("R1 cs high pre-all",      1, 0, 1, 0, 2'd0, 13'h0400);
    issue("R3 precharge b0",         0, 0, 1, 0, 2'd0, 13'h0000);
    issue("R12 all idle",            1, 1, 1, 1, 2'd0, 13'h0000);
    issue("R2 activate b1",          0, 0, 1, 1, 2'd1, 13'h0155);
    issue("R2 activate b3",          0, 0, 1, 1, 2'd3, 13'h1000);
    issue("R3 precharge b2 idle",    0, 0, 1, 0, 2'd2, 13'h0000);
    issue("R4 precharge all",        0, 0, 1, 0, 2'd2, 13'h0400);
    issue("R8 mode set",             0, 0, 0, 0, 2'd0, 13'h0237);
    issue("R9 refresh",              0, 0, 0, 1, 2'd1, 13'h1FFF);
    issue("R9 burst stop nop",       0, 1, 1, 0, 2'd1, 13'h0000);
    issue("R2 activate b1 again",    0, 0, 1, 1, 2'd1, 13'h0AAA);
    issue("R6 read b1 autopre",      0, 1, 0, 1, 2'd1, 13'h05FF);
    issue("R6 act same edge keeps",  0, 0, 1, 1, 2'd1, 13'h0777);
    issue("R6 write b1 autopre",     0, 1, 0, 0, 2'd1, 13'h0401);
    issue("R7 read closing b1",      0, 1, 0, 1, 2'd1, 13'h0002);
    issue("R11 write b0 idle",       0, 1, 0, 0, 2'd0, 13'h0003);
    issue("R1 cs high mode",         1, 0, 0, 0, 2'd0, 13'h1111);
    issue("R1 trailing nop",         1, 1, 1, 1, 2'd0, 13'h0000);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule